// File: doc/BRIEF.md
# 66-Bit Block Line Coder with Self-Synchronous Scrambling

This block pairs a transmit encoder with a receive decoder for a line code that carries 64 payload bits and a 2-bit sync header in every 66-bit block. On the transmit side, a 64-bit payload and a data/control flag are accepted. The payload is scrambled by a multiplicative, self-synchronous scrambler with polynomial 1 + x^39 + x^58. The header that matches the flag is placed in front of it, and the header does not pass through the scrambler. On the receive side, the header is classified and the payload is descrambled by the matching self-synchronous descrambler. The payload is returned with its flag and a flag that marks an illegal header.

Each direction moves one block per clock. Each direction has a single output register and uses valid/ready flow control at both ends. The descrambler history is filled only from received line bits, so no seed exchange is needed. After a reset or a line bit error, the descrambler output becomes correct again on its own once 58 clean bits have been received. Searching for block lock, width conversion for a serializer and the meaning of control type codes are left to neighbouring blocks.

Top module: `pcs66_codec`

## Requirements
- R1: While `rst_ni` is low and directly after reset, `line_valid_o` and `rx_out_valid_o` are 0, and `tx_ready_o` and `rx_ready_o` are 1.
- R2: The sync header is sent in `line_blk_o[1:0]`. Its value is 2'b01 when `tx_ctrl_i` was 0 (data block) and 2'b10 when `tx_ctrl_i` was 1 (control block).
- R3: The scrambled payload is in `line_blk_o[65:2]`, with payload bit i in line bit i+2. The payload is scrambled from bit 0 upward. Each line bit equals the payload bit XOR the line bits sent 39 and 58 positions earlier. After reset, the history of the 58 most recent line bits is all ones.
- R4: The scrambler history advances only when a block is accepted on the transmit input. The descrambler history advances only when a block is accepted on the receive input. A stalled offer changes neither history.
- R5: While an output is valid and its ready input is low, that output and its payload stay unchanged.
- R6: A side accepts a new block in a cycle only when its output register is empty or is being drained in that cycle. In particular, `tx_ready_o` is 0 while `line_valid_o` is 1 and `line_ready_i` is 0.
- R7: The receive header 2'b01 gives `rx_ctrl_o`=0 and 2'b10 gives `rx_ctrl_o`=1, both with `rx_hdr_err_o`=0. The headers 2'b00 and 2'b11 give `rx_hdr_err_o`=1 and `rx_ctrl_o`=0. The payload is still descrambled, and the history still advances.
- R8: When `line_blk_o` is looped back to `rx_blk_i`, every block returns its original payload and flag in order.
- R9: A single flipped received payload bit at position j corrupts decoded bits j, j+39 and j+58, counted across block boundaries. Every later bit decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | Transmit payload offered |
| tx_ready_o | output | 1 | Transmit side can accept |
| tx_data_i | input | 64 | Payload to encode |
| tx_ctrl_i | input | 1 | 1 = control block, 0 = data block |
| line_valid_o | output | 1 | Encoded block valid |
| line_ready_i | input | 1 | Line consumer ready |
| line_blk_o | output | 66 | Encoded block, header in [1:0] |
| rx_valid_i | input | 1 | Received block offered |
| rx_ready_o | output | 1 | Receive side can accept |
| rx_blk_i | input | 66 | Received block, header in [1:0] |
| rx_out_valid_o | output | 1 | Decoded payload valid |
| rx_out_ready_i | input | 1 | Decoded payload consumer ready |
| rx_data_o | output | 64 | Descrambled payload |
| rx_ctrl_o | output | 1 | Decoded control flag |
| rx_hdr_err_o | output | 1 | Illegal header received |

## Verification
Two functions can fall in the same cycle. The first is a stall, where an output is held and its history frozen, and the second is a fresh offer on the input behind it. The bench provokes this by holding the decoded-output ready low while the encoder keeps offering blocks. This fills both registers, and the stall then backs up through the loopback to `tx_ready_o`. The held values must not move during the stall. After release, the next encoded block must match an independent bit-serial model, which only holds if neither history moved during the stall. A header error and a payload bit error are also injected into the loopback. Their effects are compared with the exact error pattern that the polynomial predicts.

// File: rtl/pcs66_pkg.sv
package pcs66_pkg;
  localparam int unsigned PAY_W    = 64;
  localparam int unsigned HDR_W    = 2;
  localparam int unsigned BLK_W    = PAY_W + HDR_W;
  localparam int unsigned HIST_W   = 58;
  localparam int unsigned TAP_NEAR = 39;
  localparam int unsigned TAP_FAR  = 58;

  localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
  localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

  typedef enum logic [1:0] {
    HK_DATA,
    HK_CTRL,
    HK_BAD
  } hdr_kind_e;

  function automatic hdr_kind_e classify_hdr(input logic [HDR_W-1:0] h);
    if (h == HDR_DATA)      return HK_DATA;
    else if (h == HDR_CTRL) return HK_CTRL;
    else                    return HK_BAD;
  endfunction
endpackage

// File: rtl/pcs66_mult_core.sv
// Unrolled bit-serial multiplicative (de)scrambler; LSB first, hist[0] newest line bit.
module pcs66_mult_core #(
  parameter int unsigned PAY_W      = 64,
  parameter int unsigned HIST_W     = 58,
  parameter int unsigned TAP_NEAR   = 39,
  parameter int unsigned TAP_FAR    = 58,
  parameter bit          DESCRAMBLE = 1'b0
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic [PAY_W-1:0]  din_i,
  output logic [PAY_W-1:0]  dout_o,
  output logic [HIST_W-1:0] hist_o
);
  if (DESCRAMBLE) begin : g_descr
    // History is filled from the incoming (line) bits.
    always_comb begin
      logic [HIST_W-1:0] h;
      h = hist_i;
      for (int i = 0; i < PAY_W; i++) begin
        dout_o[i] = din_i[i] ^ h[TAP_NEAR-1] ^ h[TAP_FAR-1];
        h = {h[HIST_W-2:0], din_i[i]};
      end
      hist_o = h;
    end
  end else begin : g_scr
    // History is filled from the outgoing (line) bits.
    always_comb begin
      logic [HIST_W-1:0] h;
      logic              b;
      h = hist_i;
      for (int i = 0; i < PAY_W; i++) begin
        b = din_i[i] ^ h[TAP_NEAR-1] ^ h[TAP_FAR-1];
        dout_o[i] = b;
        h = {h[HIST_W-2:0], b};
      end
      hist_o = h;
    end
  end
endmodule

// File: rtl/pcs66_tx.sv
module pcs66_tx
  import pcs66_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PAY_W-1:0]  in_data_i,
  input  logic              in_ctrl_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BLK_W-1:0]  out_blk_o,
  output logic [HIST_W-1:0] state_o
);
  logic [HIST_W-1:0] hist_q, hist_d;
  logic [PAY_W-1:0]  scr;
  logic              valid_q;
  logic [BLK_W-1:0]  blk_q;
  logic              accept;

  pcs66_mult_core #(
    .PAY_W(PAY_W), .HIST_W(HIST_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR),
    .DESCRAMBLE(1'b0)
  ) u_scr (
    .hist_i(hist_q),
    .din_i (in_data_i),
    .dout_o(scr),
    .hist_o(hist_d)
  );

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '1;
      valid_q <= 1'b0;
      blk_q   <= '0;
    end else if (accept) begin
      hist_q  <= hist_d;
      valid_q <= 1'b1;
      blk_q   <= {scr, (in_ctrl_i ? HDR_CTRL : HDR_DATA)};
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_blk_o   = blk_q;
  assign state_o     = hist_q;
endmodule

// File: rtl/pcs66_rx.sv
module pcs66_rx
  import pcs66_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BLK_W-1:0]  in_blk_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [PAY_W-1:0]  out_data_o,
  output logic              out_ctrl_o,
  output logic              out_err_o,
  output logic [HIST_W-1:0] state_o
);
  logic [HIST_W-1:0] hist_q, hist_d;
  logic [PAY_W-1:0]  descr;
  logic              valid_q, ctrl_q, err_q;
  logic [PAY_W-1:0]  data_q;
  logic              accept;
  hdr_kind_e         kind;

  pcs66_mult_core #(
    .PAY_W(PAY_W), .HIST_W(HIST_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR),
    .DESCRAMBLE(1'b1)
  ) u_descr (
    .hist_i(hist_q),
    .din_i (in_blk_i[BLK_W-1:HDR_W]),
    .dout_o(descr),
    .hist_o(hist_d)
  );

  assign kind       = classify_hdr(in_blk_i[HDR_W-1:0]);
  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '1;
      valid_q <= 1'b0;
      data_q  <= '0;
      ctrl_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      // Payload is descrambled even under a bad header to keep history aligned.
      hist_q  <= hist_d;
      valid_q <= 1'b1;
      data_q  <= descr;
      ctrl_q  <= (kind == HK_CTRL);
      err_q   <= (kind == HK_BAD);
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
  assign out_ctrl_o  = ctrl_q;
  assign out_err_o   = err_q;
  assign state_o     = hist_q;
endmodule

// File: rtl/pcs66_codec.sv
module pcs66_codec
  import pcs66_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [PAY_W-1:0]  tx_data_i,
  input  logic              tx_ctrl_i,
  output logic              line_valid_o,
  input  logic              line_ready_i,
  output logic [BLK_W-1:0]  line_blk_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [BLK_W-1:0]  rx_blk_i,
  output logic              rx_out_valid_o,
  input  logic              rx_out_ready_i,
  output logic [PAY_W-1:0]  rx_data_o,
  output logic              rx_ctrl_o,
  output logic              rx_hdr_err_o
);
  logic [HIST_W-1:0] tx_hist;
  logic [HIST_W-1:0] rx_hist;

  pcs66_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (tx_valid_i),
    .in_ready_o (tx_ready_o),
    .in_data_i  (tx_data_i),
    .in_ctrl_i  (tx_ctrl_i),
    .out_valid_o(line_valid_o),
    .out_ready_i(line_ready_i),
    .out_blk_o  (line_blk_o),
    .state_o    (tx_hist)
  );

  pcs66_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (rx_valid_i),
    .in_ready_o (rx_ready_o),
    .in_blk_i   (rx_blk_i),
    .out_valid_o(rx_out_valid_o),
    .out_ready_i(rx_out_ready_i),
    .out_data_o (rx_data_o),
    .out_ctrl_o (rx_ctrl_o),
    .out_err_o  (rx_hdr_err_o),
    .state_o    (rx_hist)
  );
endmodule

// File: rtl/pcs66_codec_chk.sv
module pcs66_codec_chk
  import pcs66_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              line_valid_o,
  input logic              line_ready_i,
  input logic [BLK_W-1:0]  line_blk_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              rx_out_valid_o,
  input logic              rx_out_ready_i,
  input logic [PAY_W-1:0]  rx_data_o,
  input logic              rx_ctrl_o,
  input logic              rx_hdr_err_o,
  input logic [HIST_W-1:0] tx_hist,
  input logic [HIST_W-1:0] rx_hist
);
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!line_valid_o && !rx_out_valid_o));

  a_r2_hdr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> (line_blk_o[1:0] == HDR_DATA || line_blk_o[1:0] == HDR_CTRL));

  a_r4_tx_hist_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_valid_i && tx_ready_o) |=> $stable(tx_hist));

  a_r4_rx_hist_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_i && rx_ready_o) |=> $stable(rx_hist));

  a_r5_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && !line_ready_i) |=> (line_valid_o && $stable(line_blk_o)));

  a_r5_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_out_valid_o && !rx_out_ready_i) |=>
      (rx_out_valid_o && $stable(rx_data_o) && $stable(rx_ctrl_o) && $stable(rx_hdr_err_o)));

  a_r6_tx_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && !line_ready_i) |-> !tx_ready_o);

  a_r6_rx_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_out_valid_o && !rx_out_ready_i) |-> !rx_ready_o);

  a_r7_err_not_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_out_valid_o && rx_hdr_err_o) |-> !rx_ctrl_o);
endmodule

bind pcs66_codec pcs66_codec_chk u_chk (.*);

// File: tb/tb_pcs66_codec.sv
module tb_pcs66_codec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o;
  logic [63:0] tx_data_i = '0;
  logic        tx_ctrl_i = 1'b0;
  logic        line_valid_o;
  logic        line_ready_i;
  logic [65:0] line_blk_o;
  logic        rx_valid_i;
  logic        rx_ready_o;
  logic [65:0] rx_blk_i;
  logic        rx_out_valid_o;
  logic        rx_out_ready_i = 1'b1;
  logic [63:0] rx_data_o;
  logic        rx_ctrl_o;
  logic        rx_hdr_err_o;
  logic [65:0] flip_mask = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [57:0] m_tx, m_rx;

  always #2 clk_i = ~clk_i;

  // Loopback with optional bit corruption.
  assign rx_valid_i   = line_valid_o;
  assign rx_blk_i     = line_blk_o ^ flip_mask;
  assign line_ready_i = rx_ready_o;

  pcs66_codec dut (.*);

  // Vector: {expected header, ctrl flag, payload}
  localparam logic [66:0] VEC [0:7] = '{
    {2'b01, 1'b0, 64'h0000_0000_0000_0000},
    {2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b10, 1'b1, 64'h1E00_0000_0000_0000},
    {2'b01, 1'b0, 64'h0123_4567_89AB_CDEF},
    {2'b10, 1'b1, 64'h7800_0000_0000_00FF},
    {2'b01, 1'b0, 64'hAAAA_5555_AAAA_5555},
    {2'b01, 1'b0, 64'h8000_0000_0000_0001},
    {2'b10, 1'b1, 64'hDEAD_BEEF_CAFE_F00D}
  };

  // Bit-serial model: line bit = in ^ line[-39] ^ line[-58]; h[0] newest line bit.
  function automatic logic [63:0] m_run(input logic [63:0] d, input bit descr,
                                        inout logic [57:0] h);
    logic [63:0] o;
    for (int i = 0; i < 64; i++) begin
      o[i] = d[i] ^ h[38] ^ h[57];
      h = {h[56:0], (descr ? d[i] : o[i])};
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [65:0] act,
                     input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One block end to end through the loopback.
  task automatic run_block(input logic [63:0] d, input logic c, input logic [1:0] exp_hdr,
                           input logic [65:0] mask, input bit exp_err,
                           output logic [63:0] got);
    logic [63:0] exp_scr, exp_dec;
    @(negedge clk_i);
    tx_valid_i = 1'b1; tx_data_i = d; tx_ctrl_i = c; flip_mask = mask;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    exp_scr = m_run(d, 1'b0, m_tx);
    chk(line_valid_o, "R2 line valid", {65'd0, line_valid_o}, 66'd1);
    chk(line_blk_o[1:0] == exp_hdr, "R2 header", {64'd0, line_blk_o[1:0]}, {64'd0, exp_hdr});
    chk(line_blk_o[65:2] == exp_scr, "R3 scrambled payload", {2'd0, line_blk_o[65:2]},
        {2'd0, exp_scr});
    exp_dec = m_run(line_blk_o[65:2] ^ mask[65:2], 1'b1, m_rx);
    @(negedge clk_i);
    flip_mask = '0;
    got = rx_data_o;
    chk(rx_out_valid_o, "R8 rx valid", {65'd0, rx_out_valid_o}, 66'd1);
    chk(rx_data_o == exp_dec, "R8 rx payload", {2'd0, rx_data_o}, {2'd0, exp_dec});
    chk(rx_hdr_err_o == exp_err, "R7 header error flag", {65'd0, rx_hdr_err_o},
        {65'd0, exp_err});
    chk(rx_ctrl_o == (exp_err ? 1'b0 : c), "R7 rx ctrl flag", {65'd0, rx_ctrl_o},
        {65'd0, (exp_err ? 1'b0 : c)});
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    m_tx = '1;
    m_rx = '1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] got;
    logic [63:0] a_d, b_d, c_d, exp_b, exp_c;
    do_reset();

    // R1: idle after reset
    @(negedge clk_i);
    chk(!line_valid_o && !rx_out_valid_o, "R1 outputs idle",
        {64'd0, line_valid_o, rx_out_valid_o}, 66'd0);
    chk(tx_ready_o && rx_ready_o, "R1 inputs ready", {64'd0, tx_ready_o, rx_ready_o}, 66'd3);

    // R2 R3 R8: table walk
    for (int k = 0; k < 8; k++) begin
      run_block(VEC[k][63:0], VEC[k][64], VEC[k][66:65], '0, 1'b0, got);
      chk(got == VEC[k][63:0], "R8 original payload returned", {2'd0, got},
          {2'd0, VEC[k][63:0]});
    end

    // R7: header 00 (data 01 with bit0 flipped) and 11 (ctrl 10 with bit0 flipped)
    run_block(64'h1111_2222_3333_4444, 1'b0, 2'b01, 66'h1, 1'b1, got);
    chk(got == 64'h1111_2222_3333_4444, "R7 payload kept under bad header", {2'd0, got},
        {2'd0, 64'h1111_2222_3333_4444});
    run_block(64'h5555_6666_7777_8888, 1'b1, 2'b10, 66'h1, 1'b1, got);
    run_block(64'h0F0F_0F0F_F0F0_F0F0, 1'b1, 2'b10, '0, 1'b0, got);
    chk(got == 64'h0F0F_0F0F_F0F0_F0F0, "R7 history aligned after bad header", {2'd0, got},
        {2'd0, 64'h0F0F_0F0F_F0F0_F0F0});

    // R9: flip payload bit 10 -> errors at 10, 49, then bit 4 of next block
    run_block(64'h2468_ACE0_1357_9BDF, 1'b0, 2'b01, 66'd1 << 12, 1'b0, got);
    chk((got ^ 64'h2468_ACE0_1357_9BDF) == ((64'd1 << 10) | (64'd1 << 49)),
        "R9 error pattern block k", {2'd0, got ^ 64'h2468_ACE0_1357_9BDF},
        {2'd0, (64'd1 << 10) | (64'd1 << 49)});
    run_block(64'hFEDC_BA98_7654_3210, 1'b0, 2'b01, '0, 1'b0, got);
    chk((got ^ 64'hFEDC_BA98_7654_3210) == (64'd1 << 4), "R9 error pattern block k+1",
        {2'd0, got ^ 64'hFEDC_BA98_7654_3210}, {2'd0, 64'd1 << 4});
    run_block(64'h0000_FFFF_0000_FFFF, 1'b1, 2'b10, '0, 1'b0, got);
    chk(got == 64'h0000_FFFF_0000_FFFF, "R9 resynchronized block k+2", {2'd0, got},
        {2'd0, 64'h0000_FFFF_0000_FFFF});

    // R4 R5 R6: stall with offers pending
    a_d = 64'hA1A1_A1A1_A1A1_A1A1;
    b_d = 64'hB2B2_B2B2_B2B2_B2B2;
    c_d = 64'hC3C3_C3C3_C3C3_C3C3;
    @(negedge clk_i);
    rx_out_ready_i = 1'b0;
    tx_valid_i = 1'b1; tx_data_i = a_d; tx_ctrl_i = 1'b0;
    @(negedge clk_i);
    void'(m_run(a_d, 1'b0, m_tx));
    tx_data_i = b_d;
    @(negedge clk_i);
    exp_b = m_run(b_d, 1'b0, m_tx);
    tx_data_i = c_d;
    repeat (3) @(negedge clk_i);
    chk(rx_out_valid_o && rx_data_o == a_d, "R5 rx output held", {2'd0, rx_data_o},
        {2'd0, a_d});
    chk(line_valid_o && line_blk_o[65:2] == exp_b, "R5 line output held",
        {2'd0, line_blk_o[65:2]}, {2'd0, exp_b});
    chk(!tx_ready_o && !rx_ready_o, "R6 inputs blocked while stalled",
        {64'd0, tx_ready_o, rx_ready_o}, 66'd0);
    rx_out_ready_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    exp_c = m_run(c_d, 1'b0, m_tx);
    chk(rx_data_o == b_d, "R8 second block after release", {2'd0, rx_data_o}, {2'd0, b_d});
    chk(line_blk_o[65:2] == exp_c, "R4 scrambler history frozen during stall",
        {2'd0, line_blk_o[65:2]}, {2'd0, exp_c});
    @(negedge clk_i);
    chk(rx_data_o == c_d, "R4 descrambler history frozen during stall", {2'd0, rx_data_o},
        {2'd0, c_d});
    m_rx = m_tx;

    // R3: history back to all ones after a second reset
    do_reset();
    run_block(64'h0000_0000_0000_0000, 1'b0, 2'b01, '0, 1'b0, got);
    chk(got == 64'd0, "R3 history reset to all ones", {2'd0, got}, 66'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule